// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the control and status state that sits next to a floating-point datapath. It has three exception fields and a two-bit rounding-mode selector. The cause field records the exceptions of the most recent operation. The enable field chooses which exceptions may trap. The flag field is sticky: it accumulates every exception seen since software last cleared it.

When the datapath finishes an operation, it pulses `op_done` together with a five-bit exception vector. The block then replaces the cause field and ORs the vector into the flags. If any raised exception is enabled, it issues a one-cycle trap request. The datapath reads its effective rounding mode from `rm_out`. The CPU side reads and writes the whole 32-bit word through a simple write-enable port.

The five exception bits are ordered invalid (V), divide-by-zero (Z), overflow (O), underflow (U) and inexact (I), from most to least significant, in the vector and in every field. The cause field has one more bit above V, the error bit E. E can never be set.

Top module: `fpcsr_top`

## Requirements
- R1: After a synchronous active-low reset the word reads 32'h0000_0001: all exception fields are zero and rounding code 01 (round-to-zero) is selected.
- R2: The word layout is: cause E at bit 17, cause V,Z,O,U,I at bits 16..12, enable V..I at bits 11..7, flag V..I at bits 6..2, rounding code at bits 1..0.
- R3: A cycle with `op_done` high replaces the cause bits 16..12 with `op_exc` (bit 4 = V down to bit 0 = I). Cause bits from earlier operations are cleared.
- R4: A cycle with `op_done` high and no CPU write sets flag bits to their old value ORed with `op_exc`. Flags are never cleared by an operation.
- R5: A CPU write with no operation loads cause bits 16..12, enable bits 11..7, flag bits 6..2 and rounding bits 1..0 from `cpu_wdata`.
- R6: When a CPU write and `op_done` share a cycle, cause takes `op_exc`, flags take `cpu_wdata[6:2] | op_exc`, and enable and rounding take the written data.
- R7: `trap_req` is high in the cycle after an `op_done` cycle exactly when `op_exc` ANDed with the enable field held before that edge is non-zero. Otherwise it is low.
- R8: The rounding code is stored and read back as written, reserved codes 10 and 11 included. `rm_out` gives 00 for stored 00, 01 for stored 01, and 00 (round-to-nearest) for stored 10 or 11.
- R9: Bits 31..18 and the cause E bit 17 always read zero, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe for the whole word |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Current register word |
| op_done | input | 1 | Datapath completed an operation this cycle |
| op_exc | input | 5 | Exceptions of that operation, V..I |
| rm_out | output | 2 | Effective rounding mode to the datapath |
| trap_req | output | 1 | One-cycle trap request |

## Verification
Every stored bit is visible on `cpu_rdata` one clock after the edge that writes it. A wrong cause, flag, enable or rounding bit therefore shows up at the very next sample after the operation or write that produced it. A trap computed from the wrong enable state, or held for longer than it should be, is visible on `trap_req` in that same following cycle. The reserved rounding codes only show their effect on `rm_out`, so that output is compared against the stored code for all four values.

// File: rtl/fpcsr_pkg.sv
// Package: shared widths, field positions and rounding codes for the
// floating-point status/control register. Assumes the fixed word layout
// cause(E+5) | enable(5) | flag(5) | rounding(2) from bit 17 down to bit 0.
package fpcsr_pkg;
    localparam int NEXC      = 5;
    localparam int RM_W      = 2;
    localparam int DATA_W    = 32;
    localparam int FLAG_LSB  = RM_W;
    localparam int EN_LSB    = FLAG_LSB + NEXC;
    localparam int CAUSE_LSB = EN_LSB + NEXC;
    localparam int ERR_BIT   = CAUSE_LSB + NEXC;
    localparam int USED_W    = ERR_BIT + 1;

    typedef logic [NEXC-1:0] exc_t;

    typedef enum logic [RM_W-1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_RSVD2   = 2'b10,
        RM_RSVD3   = 2'b11
    } rm_e;
endpackage

// File: rtl/fpcsr_fields.sv
// Module: storage for cause, enable, sticky flag and raw rounding code.
// Assumes op_done marks one completed operation per cycle. An operation
// overrides a same-cycle CPU write for cause and ORs into the written flags.
module fpcsr_fields
    import fpcsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  exc_t            w_cause,
    input  exc_t            w_en,
    input  exc_t            w_flag,
    input  logic [RM_W-1:0] w_rm,
    input  logic            op_done,
    input  exc_t            op_exc,
    output exc_t            cause,
    output exc_t            en,
    output exc_t            flag,
    output logic [RM_W-1:0] rm_raw
);
    // Cause: wiped and reloaded by each operation, else loaded by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)       cause <= '0;
        else if (op_done) cause <= op_exc;
        else if (we)      cause <= w_cause;
    end

    // Enable and rounding code: written only by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= '0;
            rm_raw <= RM_ZERO;
        end else if (we) begin
            en     <= w_en;
            rm_raw <= w_rm;
        end
    end

    // Sticky flags, one cell per exception bit.
    for (genvar i = 0; i < NEXC; i++) begin : g_flag
        logic base;
        // Base value: written bit if the CPU writes, else the held bit.
        always_comb base = we ? w_flag[i] : flag[i];
        // Flag bit: base ORed with this operation's exception bit.
        always_ff @(posedge clk) begin
            if (!rst_n) flag[i] <= 1'b0;
            else        flag[i] <= base | (op_done & op_exc[i]);
        end
    end
endmodule

// File: rtl/fpcsr_trap.sv
// Module: one-cycle trap request generator. Assumes the enable field
// sampled is the value held before the edge of the completing operation.
module fpcsr_trap
    import fpcsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_done,
    input  exc_t op_exc,
    input  exc_t en,
    output logic trap_req
);
    // Trap register: set when any raised exception is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_req <= 1'b0;
        else        trap_req <= op_done && |(op_exc & en);
    end
endmodule

// File: rtl/fpcsr_rmode.sv
// Module: maps the stored rounding code to the effective datapath mode.
// Assumes reserved codes behave as round-to-nearest.
module fpcsr_rmode
    import fpcsr_pkg::*;
(
    input  logic [RM_W-1:0] rm_raw,
    output logic [RM_W-1:0] rm_eff
);
    // Decode: pass valid codes, fold reserved ones onto round-to-nearest.
    always_comb begin
        case (rm_e'(rm_raw))
            RM_NEAREST: rm_eff = RM_NEAREST;
            RM_ZERO:    rm_eff = RM_ZERO;
            default:    rm_eff = RM_NEAREST;
        endcase
    end
endmodule

// File: rtl/fpcsr_top.sv
// Module: floating-point status/control register top. Splits the CPU word
// into fields, assembles the read word, and exposes the rounding mode and
// trap request. Assumes a single clock and a synchronous active-low reset.
module fpcsr_top
    import fpcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              op_done,
    input  logic [NEXC-1:0]   op_exc,
    output logic [RM_W-1:0]   rm_out,
    output logic              trap_req
);
    exc_t            cause, en, flag;
    logic [RM_W-1:0] rm_raw;
    logic            unused_wbits;

    assign unused_wbits = ^cpu_wdata[DATA_W-1:ERR_BIT];

    fpcsr_fields u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cpu_we),
        .w_cause (cpu_wdata[CAUSE_LSB +: NEXC]),
        .w_en    (cpu_wdata[EN_LSB +: NEXC]),
        .w_flag  (cpu_wdata[FLAG_LSB +: NEXC]),
        .w_rm    (cpu_wdata[RM_W-1:0]),
        .op_done (op_done),
        .op_exc  (op_exc),
        .cause   (cause),
        .en      (en),
        .flag    (flag),
        .rm_raw  (rm_raw)
    );

    fpcsr_trap u_trap (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_done  (op_done),
        .op_exc   (op_exc),
        .en       (en),
        .trap_req (trap_req)
    );

    fpcsr_rmode u_rmode (
        .rm_raw (rm_raw),
        .rm_eff (rm_out)
    );

    // Read word: unused upper bits and the error cause bit are always zero.
    always_comb begin
        cpu_rdata = '0;
        cpu_rdata[CAUSE_LSB +: NEXC] = cause;
        cpu_rdata[EN_LSB +: NEXC]    = en;
        cpu_rdata[FLAG_LSB +: NEXC]  = flag;
        cpu_rdata[RM_W-1:0]          = rm_raw;
    end
endmodule

// File: rtl/fpcsr_checks.sv
// Module: property checker for fpcsr_top, observing only its ports.
// Assumes it is attached with the bind below.
module fpcsr_checks
    import fpcsr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_we,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              op_done,
    input logic [NEXC-1:0]   op_exc,
    input logic [RM_W-1:0]   rm_out,
    input logic              trap_req
);
    AST_RESET_WORD: assert property (@(posedge clk)
        !rst_n |=> cpu_rdata == 32'h0000_0001); // R1

    AST_CAUSE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> cpu_rdata[CAUSE_LSB +: NEXC] == $past(op_exc)); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !cpu_we) |=> cpu_rdata[FLAG_LSB +: NEXC] ==
            ($past(cpu_rdata[FLAG_LSB +: NEXC]) | $past(op_exc))); // R4

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !op_done) |=> cpu_rdata[ERR_BIT-1:0] ==
            $past(cpu_wdata[ERR_BIT-1:0])); // R5

    AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && op_done) |=> cpu_rdata[FLAG_LSB +: NEXC] ==
            ($past(cpu_wdata[FLAG_LSB +: NEXC]) | $past(op_exc))); // R6

    AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> trap_req ==
            $past(op_done && |(op_exc & cpu_rdata[EN_LSB +: NEXC]))); // R7

    AST_RM_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[1] |-> rm_out == RM_NEAREST); // R8

    AST_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[DATA_W-1:ERR_BIT] == '0); // R9
endmodule

bind fpcsr_top fpcsr_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .op_done   (op_done),
    .op_exc    (op_exc),
    .rm_out    (rm_out),
    .trap_req  (trap_req)
);

// File: tb/sim_fpcsr_top.sv
module sim_fpcsr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        op_done = 1'b0;
    logic [4:0]  op_exc = '0;
    logic [1:0]  rm_out;
    logic        trap_req;

    int n_checks = 0;
    int n_errors = 0;

    // bench model of the register
    logic [4:0] m_cause, m_en, m_flag;
    logic [1:0] m_rm;
    logic       m_trap;

    always #4 clk = ~clk;

    fpcsr_top u0 (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .op_done(op_done), .op_exc(op_exc),
        .rm_out(rm_out), .trap_req(trap_req)
    );

    function automatic logic [31:0] exp_word();
        return {14'd0, 1'b0, m_cause, m_en, m_flag, m_rm};
    endfunction

    function automatic logic [1:0] exp_rm();
        return m_rm[1] ? 2'b00 : m_rm;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, model update, then checks at the next falling edge.
    task automatic step(logic we, logic [31:0] wd, logic op, logic [4:0] ex, string req);
        cpu_we = we; cpu_wdata = wd; op_done = op; op_exc = ex;
        m_trap = op && |(ex & m_en);
        if (we) begin
            m_cause = wd[16:12]; m_en = wd[11:7]; m_flag = wd[6:2]; m_rm = wd[1:0];
        end
        if (op) begin
            m_cause = ex;
            m_flag  = m_flag | ex;
        end
        @(negedge clk);
        cpu_we = 1'b0; op_done = 1'b0; op_exc = '0;
        check(req, cpu_rdata, exp_word());
        check("R7", {31'd0, trap_req}, {31'd0, m_trap});
        check("R8", {30'd0, rm_out}, {30'd0, exp_rm()});
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        m_cause = '0; m_en = '0; m_flag = '0; m_rm = 2'b01; m_trap = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset word and round-to-zero output
        check("R1", cpu_rdata, 32'h0000_0001);
        check("R1", {30'd0, rm_out}, 32'd1);
        check("R1", {31'd0, trap_req}, 32'd0);

        // R2 R5 R9: writes of walking and all-ones patterns, upper bits masked
        step(1'b1, 32'hFFFF_FFFF, 1'b0, 5'd0, "R9");
        step(1'b1, 32'h0000_0000, 1'b0, 5'd0, "R5");
        for (int b = 0; b < 32; b++)
            step(1'b1, 32'h1 << b, 1'b0, 5'd0, "R2");

        // R3 R4 R7: sweep every exception vector under three enable masks
        for (int e = 0; e < 3; e++) begin
            logic [4:0] enm;
            enm = (e == 0) ? 5'h00 : (e == 1) ? 5'h1F : 5'h15;
            step(1'b1, {20'd0, enm, 7'd1}, 1'b0, 5'd0, "R5");
            for (int x = 0; x < 32; x++) begin
                step(1'b0, 32'd0, 1'b1, 5'(x), "R3");
                step(1'b0, 32'd0, 1'b1, 5'd0, "R4");
            end
        end

        // R4: flags survive idle cycles and are cleared only by a write
        step(1'b0, 32'd0, 1'b0, 5'd0, "R4");
        step(1'b1, 32'h0000_0F81, 1'b0, 5'd0, "R5");

        // R6: write and operation in the same cycle, all vectors
        for (int x = 0; x < 32; x++)
            step(1'b1, {15'd0, 5'h0A, 5'h1F, 5'(31 - x), 2'b00}, 1'b1, 5'(x), "R6");

        // R8: all four rounding codes stored raw and folded on rm_out
        for (int r = 0; r < 4; r++)
            step(1'b1, 32'(r), 1'b0, 5'd0, "R8");

        // R1: reset again after activity
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_cause = '0; m_en = '0; m_flag = '0; m_rm = 2'b01;
        check("R1", cpu_rdata, 32'h0000_0001);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule